// File: doc/BRIEF.md
# Multidrop Address-Wake Receive Filter

This block holds the tagging and admission logic of a 9-bit multidrop wake-up mode on an asynchronous serial channel. It takes no part in baud timing, in bit sampling or in FIFO storage. On the transmit side it takes a character written to the holding register and builds the full line frame as a parallel vector. In multidrop mode that frame carries an address/data tag bit between the data bits and the stop bits. The tag value is captured from a mode bit at the moment of the write.

On the receive side an upstream deserializer delivers each character with its sampled ninth bit and its error flags. The block decides whether the character is written into the receive FIFO, and a write is what raises the ready indication. In multidrop mode a disabled receiver still watches the line and admits only characters tagged as addresses. An enabled receiver admits every character. The received tag goes into the status slot that otherwise holds the parity-error flag. Framing and break flags are reported for every character, whether or not it is admitted.

Top module: `mdrop_wake_filter`

## Requirements
- R1: While and after reset, and before any stimulus, the outputs are as follows. `tx_vld`, `rx_load`, `rx_ovr`, `rx_frm_flag` and `rx_brk_flag` are 0. `tx_frame` is all ones, and `tx_len`, `rx_wdata` and `rx_wstat` are 0.
- R2: Multidrop mode is active exactly when `mode_sel` equals 2'b11. In any other mode no tag bit is placed in the frame, a character is admitted only when `rx_en` is 1, and status bit 5 carries `rx_par_err`.
- R3: The frame is sent from bit 0 upward. Bit 0 is the start bit (0), and bits 1..DATA_W carry the data, LSB first. In multidrop mode bit DATA_W+1 is the tag and is followed by STOP_W stop bits (1), so `tx_len` = DATA_W+2+STOP_W. Otherwise the stop bits begin at bit DATA_W+1 and `tx_len` = DATA_W+1+STOP_W. Every bit at or above `tx_len` is 1.
- R4: The tag is the value of `mode_tag` in the cycle of `thr_wr`. `tx_frame` and `tx_len` hold until the next `thr_wr`, so a later change of `mode_tag` or `mode_sel` does not alter a frame already presented.
- R5: In multidrop mode with `rx_en` = 0, a character with tag 1 is admitted. A character with tag 0 is discarded: no `rx_load`, no `rx_ovr`, and `rx_wdata` and `rx_wstat` are unchanged.
- R6: With `rx_en` = 1, every character is admitted whatever its tag.
- R7: On `rx_load`, `rx_wdata` is the received data. The status word `rx_wstat` holds break in bit 7, framing error in bit 6, and in bit 5 the tag (multidrop mode) or the parity error (other modes). Bits 4..0 are 0.
- R8: `rx_frm_flag` and `rx_brk_flag` pulse for every character that carries those errors, whether it is admitted or discarded.
- R9: An admitted character that arrives while `fifo_full` is 1 produces an `rx_ovr` pulse and no `rx_load`.
- R10: Every output pulse appears exactly one clock after its input event. There are no pulses in a cycle that follows no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Channel mode field; 2'b11 selects multidrop |
| mode_tag | input | 1 | Tag to transmit: 0 data, 1 address |
| thr_wr | input | 1 | Transmit holding register write strobe |
| thr_data | input | DATA_W | Character to transmit |
| tx_vld | output | 1 | Pulse: a new frame is presented |
| tx_frame | output | DATA_W+2+STOP_W | Line frame, bit 0 sent first |
| tx_len | output | clog2(DATA_W+3+STOP_W) | Number of valid frame bits |
| rx_vld | input | 1 | Pulse: a received character is complete |
| rx_data | input | DATA_W | Received data bits |
| rx_tag | input | 1 | Received ninth bit, sampled at mid-bit |
| rx_par_err | input | 1 | Parity error from the deserializer (non-multidrop modes) |
| rx_frm_err | input | 1 | Framing error of the character |
| rx_brk | input | 1 | Break detected on the character |
| rx_en | input | 1 | Receiver enabled |
| fifo_full | input | 1 | Receive FIFO has no free slot |
| rx_load | output | 1 | Pulse: write character into FIFO and raise ready |
| rx_wdata | output | DATA_W | Data word for the FIFO |
| rx_wstat | output | 8 | Status word for the FIFO |
| rx_ovr | output | 1 | Pulse: admitted character lost to a full FIFO |
| rx_frm_flag | output | 1 | Pulse: framing error seen |
| rx_brk_flag | output | 1 | Pulse: break seen |

## Verification
A transmit write and a received character can arrive in the same cycle. Both read the mode field in that cycle, the transmit side to place or drop the tag slot and the receive side to choose its admission rule and its status bit 5. Directed cases and a long random phase drive `thr_wr` and `rx_vld` together while `mode_sel`, `mode_tag`, `rx_en` and `fifo_full` change. A behavioural model derives the expected frame and the expected admission from the same cycle's inputs and compares both sides on every clock, so a wrong or delayed mode capture on either path shows up as a mismatch.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
  localparam logic [1:0] MODE_MDROP = 2'b11;
  localparam int ST_W   = 8;
  localparam int ST_TAG = 5;
  localparam int ST_FRM = 6;
  localparam int ST_BRK = 7;
endpackage

// File: rtl/mdf_mode_dec.sv
module mdf_mode_dec (
  input  logic [1:0] mode_sel,
  output logic       md_on
);
  import mdf_pkg::*;
  always_comb md_on = (mode_sel == MODE_MDROP);
endmodule

// File: rtl/mdf_tx_tag.sv
module mdf_tx_tag #(
  parameter int DATA_W = 8,
  parameter int STOP_W = 1,
  localparam int FRAME_W = DATA_W + 2 + STOP_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               md_on,
  input  logic               mode_tag,
  input  logic               thr_wr,
  input  logic [DATA_W-1:0]  thr_data,
  output logic               tx_vld,
  output logic [FRAME_W-1:0] tx_frame,
  output logic [LEN_W-1:0]   tx_len
);
  localparam int TAG_POS = DATA_W + 1;
  localparam logic [LEN_W-1:0] LEN_MD = LEN_W'(FRAME_W);
  localparam logic [LEN_W-1:0] LEN_PL = LEN_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_nxt;
  logic [LEN_W-1:0]   len_nxt;
  logic [FRAME_W-1:0] body;

  // data slots occupy bits 1..DATA_W
  genvar g;
  generate
    for (g = 0; g < FRAME_W; g++) begin : g_slot
      if (g == 0) begin : g_start
        assign body[g] = 1'b0;
      end else if (g <= DATA_W) begin : g_data
        assign body[g] = thr_data[g-1];
      end else begin : g_mark
        assign body[g] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    frame_nxt = body;
    len_nxt   = LEN_PL;
    if (md_on) begin
      frame_nxt[TAG_POS] = mode_tag;
      len_nxt            = LEN_MD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_vld   <= 1'b0;
      tx_frame <= '1;
      tx_len   <= '0;
    end else begin
      tx_vld <= thr_wr;
      if (thr_wr) begin
        tx_frame <= frame_nxt;
        tx_len   <= len_nxt;
      end
    end
  end
endmodule

// File: rtl/mdf_rx_gate.sv
module mdf_rx_gate #(
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    md_on,
  input  logic                    rx_vld,
  input  logic [DATA_W-1:0]       rx_data,
  input  logic                    rx_tag,
  input  logic                    rx_par_err,
  input  logic                    rx_frm_err,
  input  logic                    rx_brk,
  input  logic                    rx_en,
  input  logic                    fifo_full,
  output logic                    rx_load,
  output logic [DATA_W-1:0]       rx_wdata,
  output logic [mdf_pkg::ST_W-1:0] rx_wstat,
  output logic                    rx_ovr,
  output logic                    rx_frm_flag,
  output logic                    rx_brk_flag
);
  import mdf_pkg::*;

  logic            admit;
  logic            load_nxt;
  logic            ovr_nxt;
  logic [ST_W-1:0] stat_nxt;

  always_comb begin
    admit    = rx_en | (md_on & rx_tag);
    load_nxt = rx_vld & admit & ~fifo_full;
    ovr_nxt  = rx_vld & admit & fifo_full;
    stat_nxt = '0;
    stat_nxt[ST_BRK] = rx_brk;
    stat_nxt[ST_FRM] = rx_frm_err;
    stat_nxt[ST_TAG] = md_on ? rx_tag : rx_par_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_load     <= 1'b0;
      rx_ovr      <= 1'b0;
      rx_frm_flag <= 1'b0;
      rx_brk_flag <= 1'b0;
      rx_wdata    <= '0;
      rx_wstat    <= '0;
    end else begin
      rx_load     <= load_nxt;
      rx_ovr      <= ovr_nxt;
      rx_frm_flag <= rx_vld & rx_frm_err;
      rx_brk_flag <= rx_vld & rx_brk;
      if (load_nxt) begin
        rx_wdata <= rx_data;
        rx_wstat <= stat_nxt;
      end
    end
  end
endmodule

// File: rtl/mdrop_wake_filter.sv
module mdrop_wake_filter #(
  parameter int DATA_W = 8,
  parameter int STOP_W = 1,
  localparam int FRAME_W = DATA_W + 2 + STOP_W,
  localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_sel,
  input  logic               mode_tag,
  input  logic               thr_wr,
  input  logic [DATA_W-1:0]  thr_data,
  output logic               tx_vld,
  output logic [FRAME_W-1:0] tx_frame,
  output logic [LEN_W-1:0]   tx_len,
  input  logic               rx_vld,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic               rx_tag,
  input  logic               rx_par_err,
  input  logic               rx_frm_err,
  input  logic               rx_brk,
  input  logic               rx_en,
  input  logic               fifo_full,
  output logic               rx_load,
  output logic [DATA_W-1:0]  rx_wdata,
  output logic [7:0]         rx_wstat,
  output logic               rx_ovr,
  output logic               rx_frm_flag,
  output logic               rx_brk_flag
);
  logic md_on;

  mdf_mode_dec u_dec (
    .mode_sel (mode_sel),
    .md_on    (md_on)
  );

  mdf_tx_tag #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .md_on    (md_on),
    .mode_tag (mode_tag),
    .thr_wr   (thr_wr),
    .thr_data (thr_data),
    .tx_vld   (tx_vld),
    .tx_frame (tx_frame),
    .tx_len   (tx_len)
  );

  mdf_rx_gate #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .md_on       (md_on),
    .rx_vld      (rx_vld),
    .rx_data     (rx_data),
    .rx_tag      (rx_tag),
    .rx_par_err  (rx_par_err),
    .rx_frm_err  (rx_frm_err),
    .rx_brk      (rx_brk),
    .rx_en       (rx_en),
    .fifo_full   (fifo_full),
    .rx_load     (rx_load),
    .rx_wdata    (rx_wdata),
    .rx_wstat    (rx_wstat),
    .rx_ovr      (rx_ovr),
    .rx_frm_flag (rx_frm_flag),
    .rx_brk_flag (rx_brk_flag)
  );
endmodule

// File: rtl/mdrop_wake_filter_chk.sv
module mdrop_wake_filter_chk #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode_sel,
  input logic               mode_tag,
  input logic               thr_wr,
  input logic               tx_vld,
  input logic [FRAME_W-1:0] tx_frame,
  input logic               rx_vld,
  input logic               rx_tag,
  input logic               rx_frm_err,
  input logic               rx_brk,
  input logic               rx_en,
  input logic               fifo_full,
  input logic               rx_load,
  input logic [7:0]         rx_wstat,
  input logic               rx_ovr,
  input logic               rx_frm_flag,
  input logic               rx_brk_flag
);
  logic md_in;
  logic admit_in;
  assign md_in    = (mode_sel == 2'b11);
  assign admit_in = rx_en || (md_in && rx_tag);

  AST_TX_TAG_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && $past(md_in)) |-> (tx_frame[DATA_W+1] == $past(mode_tag))); // R3

  AST_TX_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_vld |-> $stable(tx_frame)); // R4

  AST_DISCARD_DATA_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_vld && md_in && !rx_en && !rx_tag) |-> (!rx_load && !rx_ovr)); // R5

  AST_ENABLED_ADMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_vld && rx_en) |-> (rx_load || rx_ovr)); // R6

  AST_TAG_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && $past(md_in)) |-> (rx_wstat[5] == $past(rx_tag))); // R7

  AST_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_vld) |-> (rx_frm_flag == $past(rx_frm_err) && rx_brk_flag == $past(rx_brk))); // R8

  AST_FULL_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_vld && admit_in && fifo_full) |-> (rx_ovr && !rx_load)); // R9

  AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_vld) |-> (!rx_load && !rx_ovr && !rx_frm_flag && !rx_brk_flag)); // R10

  AST_TX_PULSE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld == $past(thr_wr)); // R10
endmodule

bind mdrop_wake_filter mdrop_wake_filter_chk #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_sel    (mode_sel),
  .mode_tag    (mode_tag),
  .thr_wr      (thr_wr),
  .tx_vld      (tx_vld),
  .tx_frame    (tx_frame),
  .rx_vld      (rx_vld),
  .rx_tag      (rx_tag),
  .rx_frm_err  (rx_frm_err),
  .rx_brk      (rx_brk),
  .rx_en       (rx_en),
  .fifo_full   (fifo_full),
  .rx_load     (rx_load),
  .rx_wstat    (rx_wstat),
  .rx_ovr      (rx_ovr),
  .rx_frm_flag (rx_frm_flag),
  .rx_brk_flag (rx_brk_flag)
);

// File: tb/mdrop_wake_filter_bench.sv
`timescale 1ns/1ps
module mdrop_wake_filter_bench;
  localparam int DW = 8;
  localparam int SW = 1;
  localparam int FW = DW + 2 + SW;
  localparam int LW = $clog2(FW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic mode_tag = 1'b0;
  logic thr_wr = 1'b0;
  logic [DW-1:0] thr_data = '0;
  logic tx_vld;
  logic [FW-1:0] tx_frame;
  logic [LW-1:0] tx_len;
  logic rx_vld = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic rx_tag = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
  logic rx_en = 1'b0, fifo_full = 1'b0;
  logic rx_load, rx_ovr, rx_frm_flag, rx_brk_flag;
  logic [DW-1:0] rx_wdata;
  logic [7:0] rx_wstat;

  always #4 clk = ~clk;

  mdrop_wake_filter #(.DATA_W(DW), .STOP_W(SW)) u_mdrop_wake_filter (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_tag(mode_tag),
    .thr_wr(thr_wr), .thr_data(thr_data), .tx_vld(tx_vld), .tx_frame(tx_frame),
    .tx_len(tx_len), .rx_vld(rx_vld), .rx_data(rx_data), .rx_tag(rx_tag),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .rx_en(rx_en), .fifo_full(fifo_full), .rx_load(rx_load), .rx_wdata(rx_wdata),
    .rx_wstat(rx_wstat), .rx_ovr(rx_ovr), .rx_frm_flag(rx_frm_flag),
    .rx_brk_flag(rx_brk_flag)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // reference state
  logic          e_tx_vld = 1'b0;
  logic [FW-1:0] e_frame = '1;
  int            e_len = 0;
  logic          e_load = 1'b0, e_ovr = 1'b0, e_frm = 1'b0, e_brk = 1'b0;
  logic [DW-1:0] e_wdata = '0;
  logic [7:0]    e_wstat = '0;
  string         scen = "R10";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic model_edge();
    bit md;
    bit admit;
    md = (mode_sel == 2'b11);
    e_tx_vld = thr_wr;
    if (thr_wr) begin
      int pos;
      e_len = md ? DW + 2 + SW : DW + 1 + SW;
      e_frame = '1;
      pos = 0;
      e_frame[pos] = 1'b0; pos++;
      for (int k = 0; k < DW; k++) begin e_frame[pos] = thr_data[k]; pos++; end
      if (md) begin e_frame[pos] = mode_tag; pos++; end
    end
    admit = rx_en || (md && rx_tag);
    e_load = rx_vld && admit && !fifo_full;
    e_ovr  = rx_vld && admit && fifo_full;
    e_frm  = rx_vld && rx_frm_err;
    e_brk  = rx_vld && rx_brk;
    if (e_load) begin
      e_wdata = rx_data;
      e_wstat = {rx_brk, rx_frm_err, (md ? rx_tag : rx_par_err), 5'b00000};
    end
  endtask

  task automatic compare();
    chk(tx_vld == e_tx_vld, "R10", "tx_vld", 32'(tx_vld), 32'(e_tx_vld));
    chk(tx_frame == e_frame, "R3", "tx_frame", 32'(tx_frame), 32'(e_frame));
    chk(int'(tx_len) == e_len, "R2", "tx_len", 32'(tx_len), 32'(e_len));
    chk(rx_load == e_load, scen, "rx_load", 32'(rx_load), 32'(e_load));
    chk(rx_ovr == e_ovr, "R9", "rx_ovr", 32'(rx_ovr), 32'(e_ovr));
    chk(rx_frm_flag == e_frm && rx_brk_flag == e_brk, "R8", "frm/brk flags",
        32'({rx_frm_flag, rx_brk_flag}), 32'({e_frm, e_brk}));
    chk(rx_wdata == e_wdata && rx_wstat == e_wstat, "R7", "wdata/wstat",
        32'({rx_wdata, rx_wstat}), 32'({e_wdata, e_wstat}));
  endtask

  // one clock: edge, model, compare at falling edge, clear pulses
  task automatic cyc(input string req);
    scen = req;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    thr_wr = 1'b0;
    rx_vld = 1'b0;
  endtask

  task automatic send_tx(input logic [1:0] ms, input logic tg, input logic [DW-1:0] d);
    mode_sel = ms; mode_tag = tg; thr_data = d; thr_wr = 1'b1;
  endtask

  task automatic send_rx(input logic [DW-1:0] d, input logic tg, input logic pe,
                         input logic fe, input logic bk);
    rx_data = d; rx_tag = tg; rx_par_err = pe; rx_frm_err = fe; rx_brk = bk; rx_vld = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(!tx_vld && !rx_load && !rx_ovr && !rx_frm_flag && !rx_brk_flag, "R1",
        "pulses in reset", 32'({tx_vld, rx_load, rx_ovr, rx_frm_flag, rx_brk_flag}), 0);
    chk(tx_frame == '1 && tx_len == '0, "R1", "tx reset", 32'(tx_frame), 32'({FW{1'b1}}));
    chk(rx_wdata == '0 && rx_wstat == '0, "R1", "rx reset", 32'({rx_wdata, rx_wstat}), 0);
    rst_n = 1'b1;
    cyc("R1");

    // R3 multidrop frames with both tags
    send_tx(2'b11, 1'b0, 8'hA5); cyc("R3");
    send_tx(2'b11, 1'b1, 8'h3C); cyc("R3");
    chk(tx_frame[DW+1] == 1'b1, "R3", "tag slot", 32'(tx_frame[DW+1]), 1);
    // R4 later mode change leaves frame alone
    mode_tag = 1'b0; mode_sel = 2'b00; cyc("R4");
    chk(tx_frame[DW+1] == 1'b1 && int'(tx_len) == DW + 2 + SW, "R4", "held frame",
        32'(tx_frame), 32'(e_frame));
    // R2 non-multidrop frame: no tag slot
    send_tx(2'b01, 1'b1, 8'h00); cyc("R2");
    chk(int'(tx_len) == DW + 1 + SW && tx_frame[DW+1] == 1'b1, "R2", "plain frame",
        32'(tx_len), 32'(DW + 1 + SW));

    // R5 disabled multidrop receiver
    mode_sel = 2'b11; rx_en = 1'b0; fifo_full = 1'b0;
    send_rx(8'h42, 1'b1, 1'b0, 1'b0, 1'b0); cyc("R5");
    chk(rx_load && rx_wstat[5], "R5", "address admitted", 32'({rx_load, rx_wstat[5]}), 3);
    send_rx(8'h99, 1'b0, 1'b0, 1'b1, 1'b1); cyc("R5");
    chk(!rx_load && rx_wdata == 8'h42, "R5", "data discarded", 32'(rx_wdata), 32'h42);
    chk(rx_frm_flag && rx_brk_flag, "R8", "flags on discard", 32'({rx_frm_flag, rx_brk_flag}), 3);
    // R9 full fifo, discard must not overrun
    fifo_full = 1'b1;
    send_rx(8'h11, 1'b0, 1'b0, 1'b0, 1'b0); cyc("R5");
    chk(!rx_ovr, "R5", "no overrun on discard", 32'(rx_ovr), 0);
    send_rx(8'h12, 1'b1, 1'b0, 1'b0, 1'b0); cyc("R9");
    chk(rx_ovr && !rx_load, "R9", "overrun", 32'({rx_ovr, rx_load}), 2);
    fifo_full = 1'b0;
    // R6 enabled: data tag admitted
    rx_en = 1'b1;
    send_rx(8'h77, 1'b0, 1'b1, 1'b0, 1'b0); cyc("R6");
    chk(rx_load && rx_wstat == 8'h00 && rx_wdata == 8'h77, "R6", "enabled admit",
        32'({rx_load, rx_wstat}), 32'h100);
    // R2 plain mode: parity into bit 5, disabled blocks address tag
    mode_sel = 2'b00;
    send_rx(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0); cyc("R2");
    chk(rx_wstat == 8'h60, "R2", "parity in status", 32'(rx_wstat), 32'h60);
    rx_en = 1'b0;
    send_rx(8'h66, 1'b1, 1'b0, 1'b0, 1'b0); cyc("R2");
    chk(!rx_load, "R2", "disabled plain", 32'(rx_load), 0);
    cyc("R10");

    // simultaneous transmit and receive under random conditions
    for (int n = 0; n < 3000; n++) begin
      mode_sel  = ($urandom_range(0, 1) == 1) ? 2'b11 : 2'($urandom);
      mode_tag  = 1'($urandom);
      rx_en     = 1'($urandom);
      fifo_full = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 1) begin thr_data = 8'($urandom); thr_wr = 1'b1; end
      if ($urandom_range(0, 1) == 1)
        send_rx(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      cyc("R10");
    end
    finish_run();
  end
endmodule